// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flags

This block holds the status and interrupt request state of a single DMA channel. A channel engine, which lies outside the block, sends it one-cycle event strobes: a block request has arrived, the transfer has started, the channel was aborted, an error was seen, and a block has finished. With each block-finished strobe the engine also reports whether that block closes the transaction, and whether the channel runs in unlimited-repeat mode. From these strobes the block keeps three flags: pending, error and transaction complete.

Software reaches the block through one status register. The register has a write strobe and a read port that is always valid. Each of the error and completion causes has its own 2-bit interrupt level field. Both causes share a single interrupt request output, and that output carries a priority level. Taking the interrupt does not clear a flag. Software clears the error or complete flag by writing a one to that flag's bit.

Top module: `dma_chan_flags`

## Requirements
- R1: The pending flag (read bit 6) is set by `blk_req`. It is cleared by `xfer_start` or `chan_abort`. If a request arrives in the same cycle as a start or abort, the flag ends up set. Writes to bit 6 have no effect.
- R2: The error flag (read bit 5) sets in the cycle after `err_det` is asserted.
- R3: The error flag and the complete flag (bit 4) clear only when a register write puts a one in their bit. Writing a zero to either bit leaves it unchanged. No hardware event clears either flag.
- R4: When `rpt_unlim` is low, the complete flag sets after a `blk_done` only if `txn_last` is high in the same cycle.
- R5: When `rpt_unlim` is high, the complete flag sets after every `blk_done`, whatever the value of `txn_last`.
- R6: A register write loads the error level field from bits 3:2 and the completion level field from bits 1:0. Both fields read back at the same positions. Bit 7 always reads zero.
- R7: A level of 00 disables its cause. Levels 01, 10 and 11 mean low, medium and high. `irq_lvl` is the larger of the levels of the set and enabled causes, and it is 00 when no such cause exists.
- R8: If a hardware set and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R9: After reset, every flag and every level field is zero, so `reg_rdata` and `irq_lvl` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_req | input | 1 | A block request is now waiting |
| xfer_start | input | 1 | The waiting transfer has begun |
| chan_abort | input | 1 | The channel was aborted |
| err_det | input | 1 | An error was detected on the channel |
| blk_done | input | 1 | A block transfer finished |
| txn_last | input | 1 | The finishing block ends the transaction |
| rpt_unlim | input | 1 | Unlimited-repeat mode is active |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | RDW | Register write data |
| reg_rdata | output | RDW | Register read data |
| irq_lvl | output | LVLW | Interrupt request level; 00 means no request |

## Verification
The bench uses the default parameters: RDW = 8 and LVLW = 2. With these values the flags sit at bits 6, 5 and 4, and the level fields at bits 3:2 and 1:0. In this layout every combination of level pairs can be reached, so the bench can compare the highest-level choice on the interrupt output against the levels read back from the register. Randomly timed event strobes and writes run for thousands of cycles. Because of this, request/start, set/clear and repeat-mode collisions occur many times, and directed cycles add the exact collision cases on top.

// File: rtl/dma_chan_flags.sv
module dma_chan_flags #(
  parameter int RDW  = 8,
  parameter int LVLW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_req,
  input  logic            xfer_start,
  input  logic            chan_abort,
  input  logic            err_det,
  input  logic            blk_done,
  input  logic            txn_last,
  input  logic            rpt_unlim,
  input  logic            reg_wr,
  input  logic [RDW-1:0]  reg_wdata,
  output logic [RDW-1:0]  reg_rdata,
  output logic [LVLW-1:0] irq_lvl
);
  localparam int CLV_LO = 0;
  localparam int ELV_LO = LVLW;
  localparam int CMP_B  = 2 * LVLW;
  localparam int ERR_B  = 2 * LVLW + 1;
  localparam int PND_B  = 2 * LVLW + 2;

  logic            pend_q, err_q, cmp_q;
  logic [LVLW-1:0] elvl_q, clvl_q;

  wire clr_err = reg_wr & reg_wdata[ERR_B];
  wire clr_cmp = reg_wr & reg_wdata[CMP_B];
  wire set_cmp = blk_done & (rpt_unlim | txn_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      cmp_q  <= 1'b0;
      elvl_q <= '0;
      clvl_q <= '0;
    end else begin
      pend_q <= blk_req | (pend_q & ~(xfer_start | chan_abort));
      err_q  <= err_det | (err_q & ~clr_err);
      cmp_q  <= set_cmp | (cmp_q & ~clr_cmp);
      if (reg_wr) begin
        elvl_q <= reg_wdata[ELV_LO +: LVLW];
        clvl_q <= reg_wdata[CLV_LO +: LVLW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[PND_B] = pend_q;
    reg_rdata[ERR_B] = err_q;
    reg_rdata[CMP_B] = cmp_q;
    reg_rdata[ELV_LO +: LVLW] = elvl_q;
    reg_rdata[CLV_LO +: LVLW] = clvl_q;
  end

  wire [LVLW-1:0] err_req = err_q ? elvl_q : '0;
  wire [LVLW-1:0] cmp_req = cmp_q ? clvl_q : '0;
  assign irq_lvl = (err_req > cmp_req) ? err_req : cmp_req;
endmodule

// File: rtl/dma_chan_flags_chk.sv
module dma_chan_flags_chk #(
  parameter int RDW  = 8,
  parameter int LVLW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            blk_req,
  input logic            xfer_start,
  input logic            chan_abort,
  input logic            err_det,
  input logic            blk_done,
  input logic            txn_last,
  input logic            rpt_unlim,
  input logic            reg_wr,
  input logic [RDW-1:0]  reg_wdata,
  input logic [RDW-1:0]  reg_rdata,
  input logic [LVLW-1:0] irq_lvl
);
  localparam int CMP_B = 2 * LVLW;
  localparam int ERR_B = 2 * LVLW + 1;
  localparam int PND_B = 2 * LVLW + 2;
  wire [LVLW-1:0] elvl = reg_rdata[LVLW +: LVLW];
  wire [LVLW-1:0] clvl = reg_rdata[0 +: LVLW];

  a_r1_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start || chan_abort) && !blk_req |=> !reg_rdata[PND_B]);
  a_r1_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |=> reg_rdata[PND_B]);
  a_r2_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_det |=> reg_rdata[ERR_B]);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[ERR_B] && !(reg_wr && reg_wdata[ERR_B]) |=> reg_rdata[ERR_B]);
  a_r3_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[CMP_B] && !(reg_wr && reg_wdata[CMP_B]) |=> reg_rdata[CMP_B]);
  a_r5_rpt_every_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && rpt_unlim |=> reg_rdata[CMP_B]);
  a_r4_last_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && txn_last |=> reg_rdata[CMP_B]);
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[ERR_B] && !reg_rdata[CMP_B] |-> irq_lvl == '0);
  a_r7_err_floor: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[ERR_B] |-> irq_lvl >= elvl);
  a_r7_cmp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[CMP_B] |-> irq_lvl >= clvl);
  a_r6_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RDW-1:PND_B+1] == '0);
endmodule

bind dma_chan_flags dma_chan_flags_chk #(.RDW(RDW), .LVLW(LVLW)) chk_i (
  .clk(clk), .rst_n(rst_n), .blk_req(blk_req), .xfer_start(xfer_start),
  .chan_abort(chan_abort), .err_det(err_det), .blk_done(blk_done),
  .txn_last(txn_last), .rpt_unlim(rpt_unlim), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lvl(irq_lvl));

// File: tb/dma_chan_flags_tb_top.sv
module dma_chan_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_req = 0, xfer_start = 0, chan_abort = 0, err_det = 0;
  logic blk_done = 0, txn_last = 0, rpt_unlim = 0, reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] irq_lvl;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_flags dut_i (.*);

  logic m_pend = 0, m_err = 0, m_cmp = 0;
  logic [1:0] m_el = 0, m_cl = 0;

  function automatic logic [1:0] exp_irq(logic e, logic c, logic [1:0] el, logic [1:0] cl);
    logic [1:0] a, b;
    a = e ? el : 2'd0;
    b = c ? cl : 2'd0;
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ptag, string etag, string ctag);
    chk(ptag, reg_rdata[6], m_pend);
    chk(etag, reg_rdata[5], m_err);
    chk(ctag, reg_rdata[4], m_cmp);
    chk("R6 error level", reg_rdata[3:2], m_el);
    chk("R6 completion level", reg_rdata[1:0], m_cl);
    chk("R6 bit7", reg_rdata[7], 0);
    chk("R7 irq level", irq_lvl, exp_irq(m_err, m_cmp, m_el, m_cl));
  endtask

  task automatic cyc(logic rq, logic st, logic ab, logic er, logic dn, logic ls,
                     logic rp, logic wr, logic [7:0] wd);
    string pt, et, ct;
    logic sc;
    blk_req = rq; xfer_start = st; chan_abort = ab; err_det = er;
    blk_done = dn; txn_last = ls; rpt_unlim = rp; reg_wr = wr; reg_wdata = wd;
    pt = (rq && (st || ab)) ? "R1 request wins" : "R1 pending";
    if (er && wr && wd[5]) et = "R8 error set wins";
    else if (m_err && !er) et = "R3 error kept or cleared";
    else et = "R2 error set";
    sc = dn && (rp || ls);
    if (sc && wr && wd[4]) ct = "R8 complete set wins";
    else if (dn && rp) ct = "R5 repeat complete";
    else if (dn) ct = "R4 no-repeat complete";
    else ct = "R3 complete kept or cleared";
    m_pend = rq | (m_pend & ~(st | ab));
    m_err = er | (m_err & ~(wr & wd[5]));
    m_cmp = sc | (m_cmp & ~(wr & wd[4]));
    if (wr) begin m_el = wd[3:2]; m_cl = wd[1:0]; end
    @(posedge clk);
    @(negedge clk);
    check_all(pt, et, ct);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R9 reset pending", "R9 reset error", "R9 reset complete");
    // levels, W1C and set-wins corners
    cyc(0,0,0,1,0,0,0,1,8'b0000_1110);       // R6 write levels, R2 error sets
    cyc(0,0,0,0,1,1,0,0,8'h00);              // R4 last block completes
    cyc(0,0,0,0,0,0,0,1,8'b0000_0110);       // R3 zero writes keep flags; R7 max
    cyc(0,0,0,0,0,0,0,1,8'b0111_0001);       // R3 W1C both; bit6 write ignored (R1)
    cyc(0,0,0,0,1,0,0,0,8'h00);              // R4 non-last block no set
    cyc(0,0,0,0,1,0,1,0,8'h00);              // R5 repeat sets on any block
    cyc(0,0,0,1,1,1,0,1,8'b0011_1101);       // R8 collisions on both flags
    cyc(0,0,0,0,0,0,0,1,8'b0000_0000);       // R7 levels 00 disable irq
    cyc(1,0,0,0,0,0,0,0,8'h00);              // R1 set
    cyc(1,1,0,0,0,0,0,0,8'h00);              // R1 request wins over start
    cyc(0,0,1,0,0,0,0,0,8'h00);              // R1 abort clears
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd;
      wd = 8'($urandom);
      if ($urandom_range(3) != 0) wd[5:4] = 2'b00;
      cyc($urandom_range(7) == 0, $urandom_range(5) == 0, $urandom_range(11) == 0,
          $urandom_range(9) == 0, $urandom_range(5) == 0, $urandom_range(1) == 0,
          $urandom_range(2) == 0, $urandom_range(3) == 0, wd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule